// File: doc/BRIEF.md
# Heartbeat Window Monitor

The block watches the collision-indicator line of an attachment-unit interface after each transmission ends. The external transceiver should answer every transmission with a short 10 MHz heartbeat burst. The monitor times a window from the end of transmit, checks that the burst starts late enough and early enough, and measures its length by counting line edges. At the close of the window it gives a one-cycle "seen" pulse for a good heartbeat or a one-cycle error pulse for anything else. The check runs only when the attachment-unit interface is the selected port.

While the window is open the monitor drives a gate that the receive path uses to ignore carrier activity, so that the heartbeat is not taken as an incoming frame. A new transmission abandons any window in progress with no verdict.

The block runs from a 20 MHz sample clock, so one bit time is two cycles, 0.6 µs is 12 cycles and 1.6 µs is 32 cycles. A 10 MHz burst shows a level change on every sample, which is two edges per bit time. Reset is synchronous and active low.

Top module: `sqe_window_mon`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `rx_gate`, `sqe_seen` and `sqe_err` are all 0.
- R2: If `sel_aui` is 0 in the cycle where `tx_active` is first sampled low, no window opens: `rx_gate`, `sqe_seen` and `sqe_err` stay 0 whatever `ci_in` does.
- R3: Let E0 be the clock edge that first samples `tx_active` low after it was high, with `sel_aui` 1. Window slot k (k = 0, 1, ...) is the edge E0+1+k. `rx_gate` is 1 from E0 until edge E0+63, that is at slot 62, where it returns to 0.
- R4: An edge in slot k is a `ci_in` sample at E0+1+k that differs from the sample at the edge before. If no edge falls in slots 0 to 11, at least one edge falls in slots 12 to 32, and the number of edges in slots 12 to 61 is between 10 and 30 inclusive, `sqe_seen` is 1 for the single cycle after slot 62 and `sqe_err` stays 0.
- R5: Any edge in slots 0 to 11 (a start earlier than 0.6 µs) gives `sqe_err` for the single cycle after slot 62 instead of `sqe_seen`.
- R6: No edge at all in slots 0 to 61 gives the `sqe_err` pulse after slot 62.
- R7: A burst whose first edge lies in slots 33 to 61 (a start later than 1.6 µs) gives the `sqe_err` pulse after slot 62.
- R8: Fewer than 10 edges (under 5 bit times) in slots 12 to 61 give the `sqe_err` pulse after slot 62.
- R9: More than 30 edges (over 15 bit times) in slots 12 to 61 give the `sqe_err` pulse after slot 62. Samples at slot 62 and later are not counted.
- R10: `tx_active` sampled 1 during an open window closes it: `rx_gate` is 0 after that edge and no `sqe_seen` or `sqe_err` pulse follows for that window.
- R11: `sqe_seen` and `sqe_err` are never 1 together, and each lasts exactly one cycle per window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_active | input | 1 | High while a frame is being sent |
| sel_aui | input | 1 | High when the attachment-unit interface is the active port |
| ci_in | input | 1 | Digitised collision-indicator line |
| sqe_seen | output | 1 | One-cycle pulse: valid heartbeat seen in the window |
| sqe_err | output | 1 | One-cycle pulse: heartbeat missing, early, late, short or long |
| rx_gate | output | 1 | High while the window is open; receive carrier is to be ignored |

## Verification
A slot timer that is off by one shows directly at the ports. `rx_gate` falls a cycle early or late, and a burst placed exactly on slot 11, 12, 32 or 33 gets the wrong verdict. An edge counter that drops or doubles a count, or a start flag that fails to clear between windows, shows up as a wrong verdict. It is seen in the single cycle after slot 62 of the window in question, so boundary bursts of 9, 10, 30 and 31 edges and windows after an error expose it within about 65 cycles. A stale state after an abort shows as a spurious pulse or a gate left open on the very next cycle.

// File: rtl/sqe_mon_pkg.sv
package sqe_mon_pkg;

   // Part of the window the current slot falls in
   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,
      PH_EARLY = 2'd1,
      PH_START = 2'd2,
      PH_TAIL  = 2'd3
   } sqe_phase_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WIN  = 1'b1
   } sqe_state_e;

endpackage

// File: rtl/sqe_ci_sync.sv
module sqe_ci_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_flops
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_in};
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sqe_burst_meter.sv
module sqe_burst_meter
   import sqe_mon_pkg::*;
#(
   parameter int MIN_EDGES = 10,
   parameter int MAX_EDGES = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       ci,
   input  sqe_phase_e phase,
   output logic       burst_ok
);

   localparam int SAT = MAX_EDGES + 1;
   localparam int EW  = $clog2(SAT + 1);
   localparam logic [EW-1:0] SAT_E = EW'(SAT);
   localparam logic [EW-1:0] MIN_E = EW'(MIN_EDGES);
   localparam logic [EW-1:0] MAX_E = EW'(MAX_EDGES);

   logic          ci_q;
   logic          early_q;
   logic          started_q;
   logic [EW-1:0] edges_q;
   logic          toggle;

   assign toggle = ci ^ ci_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ci_q      <= 1'b0;
         early_q   <= 1'b0;
         started_q <= 1'b0;
         edges_q   <= '0;
      end else begin
         ci_q <= ci;
         if (clear) begin
            early_q   <= 1'b0;
            started_q <= 1'b0;
            edges_q   <= '0;
         end else if (toggle) begin
            unique case (phase)
               PH_EARLY: early_q <= 1'b1;
               PH_START: begin
                  started_q <= 1'b1;
                  if (edges_q != SAT_E) edges_q <= edges_q + 1'b1;
               end
               PH_TAIL: begin
                  if (edges_q != SAT_E) edges_q <= edges_q + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign burst_ok = !early_q && started_q && (edges_q >= MIN_E) && (edges_q <= MAX_E);

   // R8
   edges_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (clear || edges_q >= $past(edges_q)));

   // R5
   early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (early_q && !clear) |=> early_q);

endmodule

// File: rtl/sqe_window_timer.sv
module sqe_window_timer
   import sqe_mon_pkg::*;
#(
   parameter int EARLY_CYC = 12,
   parameter int LATE_CYC  = 32,
   parameter int CLOSE_CYC = 62
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_active,
   input  logic       sel_aui,
   input  logic       burst_ok,
   output sqe_phase_e phase,
   output logic       clear,
   output logic       rx_gate,
   output logic       sqe_seen,
   output logic       sqe_err
);

   localparam int TW = $clog2(CLOSE_CYC + 1);
   localparam logic [TW-1:0] EARLY_T = TW'(EARLY_CYC);
   localparam logic [TW-1:0] LATE_T  = TW'(LATE_CYC);
   localparam logic [TW-1:0] CLOSE_T = TW'(CLOSE_CYC);

   sqe_state_e    st_q;
   logic [TW-1:0] slot_q;
   logic          tx_q;
   logic          tx_end;

   assign tx_end = tx_q && !tx_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         slot_q   <= '0;
         tx_q     <= 1'b0;
         sqe_seen <= 1'b0;
         sqe_err  <= 1'b0;
      end else begin
         tx_q     <= tx_active;
         sqe_seen <= 1'b0;
         sqe_err  <= 1'b0;
         if (tx_active) begin
            st_q <= ST_IDLE;
         end else if (st_q == ST_IDLE) begin
            if (tx_end && sel_aui) begin
               st_q   <= ST_WIN;
               slot_q <= '0;
            end
         end else if (slot_q == CLOSE_T) begin
            st_q     <= ST_IDLE;
            sqe_seen <= burst_ok;
            sqe_err  <= !burst_ok;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   always_comb begin
      phase = PH_OFF;
      if (st_q == ST_WIN) begin
         if (slot_q < EARLY_T)       phase = PH_EARLY;
         else if (slot_q <= LATE_T)  phase = PH_START;
         else if (slot_q < CLOSE_T)  phase = PH_TAIL;
      end
   end

   assign clear   = (st_q == ST_IDLE);
   assign rx_gate = (st_q == ST_WIN);

   // R11
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sqe_seen && sqe_err));

   // R11
   seen_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sqe_seen |=> !sqe_seen);

   // R11
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sqe_err |=> !sqe_err);

   // R10
   tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> (!rx_gate && !sqe_seen && !sqe_err));

   // R2
   non_aui_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_gate && !sel_aui) |=> !rx_gate);

   // R3
   verdict_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sqe_seen || sqe_err) |-> ($past(rx_gate) && !rx_gate));

endmodule

// File: rtl/sqe_window_mon.sv
module sqe_window_mon
   import sqe_mon_pkg::*;
#(
   parameter int CYC_PER_BIT = 2,
   parameter int EARLY_CYC   = 12,
   parameter int LATE_CYC    = 32,
   parameter int MIN_BITS    = 5,
   parameter int MAX_BITS    = 15,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active,
   input  logic sel_aui,
   input  logic ci_in,
   output logic sqe_seen,
   output logic sqe_err,
   output logic rx_gate
);

   localparam int CLOSE_CYC = LATE_CYC + MAX_BITS * CYC_PER_BIT;
   localparam int MIN_EDGES = 2 * MIN_BITS;
   localparam int MAX_EDGES = 2 * MAX_BITS;

   if (EARLY_CYC >= LATE_CYC) begin : g_bad_window
      $error("window start bound must precede its end bound");
   end
   if (MIN_BITS < 1 || MIN_BITS > MAX_BITS) begin : g_bad_len
      $error("burst length bounds are inconsistent");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES == 1) begin : g_bad_sync
      $error("synchroniser depth must be 0 or at least 2");
   end

   logic       ci_s;
   logic       clear;
   logic       burst_ok;
   sqe_phase_e phase;

   sqe_ci_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (ci_in),
      .d_out (ci_s)
   );

   sqe_burst_meter #(
      .MIN_EDGES (MIN_EDGES),
      .MAX_EDGES (MAX_EDGES)
   ) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .ci       (ci_s),
      .phase    (phase),
      .burst_ok (burst_ok)
   );

   sqe_window_timer #(
      .EARLY_CYC (EARLY_CYC),
      .LATE_CYC  (LATE_CYC),
      .CLOSE_CYC (CLOSE_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_active (tx_active),
      .sel_aui   (sel_aui),
      .burst_ok  (burst_ok),
      .phase     (phase),
      .clear     (clear),
      .rx_gate   (rx_gate),
      .sqe_seen  (sqe_seen),
      .sqe_err   (sqe_err)
   );

endmodule

// File: tb/sqe_window_mon_bench.sv
module sqe_window_mon_bench;

   localparam int EARLY = 12;
   localparam int LATE  = 32;
   localparam int CLOSE = 62;
   localparam int NSLOT = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_active = 1'b0;
   logic sel_aui = 1'b1;
   logic ci_in = 1'b0;
   logic sqe_seen, sqe_err, rx_gate;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   logic level = 1'b0;
   logic tg [NSLOT];

   always #2.5 clk = ~clk;

   sqe_window_mon u_sqe_window_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_active (tx_active),
      .sel_aui   (sel_aui),
      .ci_in     (ci_in),
      .sqe_seen  (sqe_seen),
      .sqe_err   (sqe_err),
      .rx_gate   (rx_gate)
   );

   task automatic check3(string req, logic g, logic s, logic e, logic eg, logic es, logic ee);
      vectors++;
      if (g !== eg || s !== es || e !== ee) begin
         fails++;
         $display("FAIL %s: gate/seen/err = %b%b%b expected %b%b%b at %0t", req, g, s, e, eg, es, ee, $time);
      end
   endtask

   // Toggle mask: edges at slots first..first+n-1, plus an optional early pair
   task automatic build(int first, int n, int early_at);
      for (int k = 0; k < NSLOT; k++) tg[k] = 1'b0;
      for (int k = first; k < first + n && k < NSLOT; k++) tg[k] = 1'b1;
      if (early_at >= 0) begin
         tg[early_at] = 1'b1;
         tg[early_at + 1] = 1'b1;
      end
   endtask

   function automatic bit model_ok();
      bit early = 0;
      bit started = 0;
      int edges = 0;
      for (int k = 0; k < CLOSE; k++) begin
         if (tg[k]) begin
            if (k < EARLY) early = 1;
            else begin
               edges++;
               if (k <= LATE) started = 1;
            end
         end
      end
      return !early && started && edges >= 10 && edges <= 30;
   endfunction

   // One transmission followed by its window; abort_at < 0 means no abort
   task automatic run_window(string req, bit aui, int abort_at);
      bit ok;
      bit open;
      ok = model_ok();
      open = aui;
      @(negedge clk);
      sel_aui = aui;
      tx_active = 1'b1;
      repeat (3) @(negedge clk);
      tx_active = 1'b0;
      @(posedge clk);            // E0
      @(negedge clk);
      check3(aui ? "R3" : "R2", rx_gate, sqe_seen, sqe_err, aui, 1'b0, 1'b0);
      for (int k = 0; k <= CLOSE + 1; k++) begin
         if (k == abort_at) begin
            tx_active = 1'b1;
            open = 1'b0;
         end
         if (k < NSLOT && tg[k]) level = ~level;
         ci_in = level;
         @(posedge clk);
         @(negedge clk);
         if (!open)
            check3(aui ? "R10" : "R2", rx_gate, sqe_seen, sqe_err, 1'b0, 1'b0, 1'b0);
         else if (k < CLOSE)
            check3("R3", rx_gate, sqe_seen, sqe_err, 1'b1, 1'b0, 1'b0);
         else if (k == CLOSE)
            check3(req, rx_gate, sqe_seen, sqe_err, 1'b0, ok, !ok);
         else
            check3("R11", rx_gate, sqe_seen, sqe_err, 1'b0, 1'b0, 1'b0);
      end
      tx_active = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(5 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not end, actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      int first, n, ea;
      seed = 7;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check3("R1", rx_gate, sqe_seen, sqe_err, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check3("R1", rx_gate, sqe_seen, sqe_err, 1'b0, 1'b0, 1'b0);

      build(12, 10, -1); run_window("R4", 1'b1, -1);   // earliest start, shortest burst
      build(32, 30, -1); run_window("R4", 1'b1, -1);   // latest start, longest burst
      build(20, 20, -1); run_window("R4", 1'b1, -1);
      build(11, 12, -1); run_window("R5", 1'b1, -1);   // first edge one slot early
      build(20, 20, 3);  run_window("R5", 1'b1, -1);   // glitch pair before window
      build(0, 0, -1);   run_window("R6", 1'b1, -1);   // silence
      build(33, 20, -1); run_window("R7", 1'b1, -1);   // one slot late
      build(15, 9, -1);  run_window("R8", 1'b1, -1);
      build(12, 31, -1); run_window("R9", 1'b1, -1);
      build(40, 40, -1); run_window("R9", 1'b1, -1);   // edges past slot 61 ignored? too late anyway
      build(30, 40, -1); run_window("R9", 1'b1, -1);   // 32 counted edges before slot 62
      build(20, 20, -1); run_window("R2", 1'b0, -1);   // port not selected
      build(20, 20, -1); run_window("R10", 1'b1, 25);  // restart mid-burst
      build(20, 20, -1); run_window("R4", 1'b1, -1);   // clean window after abort
      build(0, 0, -1);   run_window("R10", 1'b1, 62);  // restart on the closing slot

      for (int i = 0; i < 40; i++) begin
         first = $urandom_range(40, 5);
         n     = $urandom_range(36, 0);
         ea    = ($urandom_range(7, 0) == 0) ? int'($urandom_range(9, 0)) : -1;
         build(first, n, ea);
         run_window("R4", ($urandom_range(9, 0) != 0), -1);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule